// File: doc/BRIEF.md
# Bridge Data Parity Error Reporter

This block watches the data phases of a two-port bus bridge, one port facing the primary (host-side) bus and one facing the secondary bus. For every data phase on either port it computes even parity over the data and byte enables and compares it with the parity bit that arrives one clock later. Transaction type and direction are supplied with each phase. From them the block works out whether the bridge is responsible for signalling a data parity error on the primary side, and whether the error belongs in the secondary status bit.

Two results come out. The first is an active-low primary error strobe. The bridge pulses it for its own primary parity errors. It also pulses it when the device on the secondary bus signals an error while a downstream delayed write is completing, so the error is carried back across the bridge. The second is a sticky secondary data-parity-detected bit. It is set only for transfers that the bridge masters on the secondary bus, and software clears it by writing 1.

The bridge's role on each bus follows from the direction. On a downstream transfer the bridge is the target on the primary bus and the master on the secondary bus. On an upstream transfer it is the master on the primary bus and the target on the secondary bus.

Top module: `bridge_perr_unit`

## Requirements
- R1: While `rst` is high, and on the clock after it is released, `pri_perr_n` is 1 and `sec_dpd` is 0.
- R2: The expected parity of a phase is the XOR of all data bits and byte enables (even parity). The received parity bit is sampled on the clock after the phase. A phase with matching parity produces no error indication.
- R3: Suppose a primary phase in cycle T has a parity mismatch and the primary enable was 1 in cycle T. If that phase is a downstream write (kind 01 posted or 10 delayed, dir 0) or an upstream read (kind 00, dir 1), then `pri_perr_n` is 0 in cycle T+2 for exactly that one cycle.
- R4: A primary mismatch on a downstream read, on an upstream write, with kind 11, or with the primary enable at 0 during the phase never drives `pri_perr_n` low.
- R5: Take a secondary phase in cycle T that is a downstream delayed write (kind 10, dir 0). If `sec_perr_n` is 0 in cycle T+2 and `pri_perr_en` is 1 in cycle T+2, then `pri_perr_n` is 0 in cycle T+3 for one cycle. If `pri_perr_en` is 0 there, nothing is signalled.
- R6: `sec_perr_n` low after a downstream posted write or a downstream read on the secondary bus does not drive `pri_perr_n` low. `sec_perr_n` low outside the T+2 window of a secondary phase is ignored entirely.
- R7: `sec_dpd` becomes 1 in cycle T+3 for a secondary phase in cycle T that meets three conditions. The phase is downstream (the bridge is master). The secondary enable was 1 in cycle T. Either its parity mismatched or `sec_perr_n` was 0 in cycle T+2.
- R8: An upstream secondary phase (the bridge is target), or one with the secondary enable at 0, never sets `sec_dpd`, whether it has a mismatch or `sec_perr_n` is low.
- R9: `sec_dpd` stays 1 until `stat_clr` is 1 in some cycle, after which it reads 0. With `stat_clr` at 0 it keeps its value. If a set and `stat_clr` fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_phase | input | 1 | Data phase on the primary bus this cycle |
| pri_ad | input | DATA_W | Primary data |
| pri_be | input | BE_W | Primary byte enables |
| pri_par | input | 1 | Primary received parity, one clock after the phase |
| pri_kind | input | 2 | Primary transaction type: 00 read, 01 posted write, 10 delayed write |
| pri_dir | input | 1 | Primary transaction direction: 0 downstream, 1 upstream |
| pri_perr_en | input | 1 | Primary parity-error-response enable |
| sec_phase | input | 1 | Data phase on the secondary bus this cycle |
| sec_ad | input | DATA_W | Secondary data |
| sec_be | input | BE_W | Secondary byte enables |
| sec_par | input | 1 | Secondary received parity, one clock after the phase |
| sec_kind | input | 2 | Secondary transaction type, same encoding |
| sec_dir | input | 1 | Secondary transaction direction, same encoding |
| sec_perr_en | input | 1 | Secondary parity-error-response enable |
| sec_perr_n | input | 1 | Incoming secondary error strobe, active low |
| stat_clr | input | 1 | Write-1-to-clear pulse for the status bit |
| pri_perr_n | output | 1 | Primary error strobe, active low |
| sec_dpd | output | 1 | Sticky secondary data-parity-detected bit |

## Verification
The cross-bridge path is the hardest case to reach from the ports. It needs a downstream delayed write on the secondary side, then a low secondary strobe placed exactly two clocks later, and it must be told apart from the same strobe after a posted write or in an unrelated cycle. The driver task places `sec_perr_n` in that window for each transaction type and enable combination, and the scoreboard predicts the one-cycle pulse in T+3. A further case places a clear pulse in the very cycle that sets the status bit, which shows that the set wins.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

    typedef enum logic [1:0] {
        XK_READ       = 2'b00,
        XK_POSTED_WR  = 2'b01,
        XK_DELAYED_WR = 2'b10,
        XK_RSVD       = 2'b11
    } xfer_kind_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } xfer_dir_e;

    localparam int NUM_BUS = 2;
    localparam int BUS_PRI = 0;
    localparam int BUS_SEC = 1;

    // first pipeline stage: context captured with the data phase
    typedef struct packed {
        logic       valid;
        logic       calc_par;
        xfer_kind_e kind;
        xfer_dir_e  dir;
        logic       en;
    } phase_t;

    // second stage: parity compared, context carried along
    typedef struct packed {
        logic       valid;
        logic       mismatch;
        xfer_kind_e kind;
        xfer_dir_e  dir;
        logic       en;
    } chk_t;

    function automatic logic is_write(xfer_kind_e k);
        return (k == XK_POSTED_WR) || (k == XK_DELAYED_WR);
    endfunction

    // bridge is target of a write or initiator of a read on the primary bus
    function automatic logic pri_owns_strobe(xfer_kind_e k, xfer_dir_e d);
        return ((d == DIR_DOWN) && is_write(k)) || ((d == DIR_UP) && (k == XK_READ));
    endfunction

    function automatic logic masters_secondary(xfer_dir_e d);
        return d == DIR_DOWN;
    endfunction

endpackage

// File: rtl/bpe_parity_pipe.sv
module bpe_parity_pipe
    import bpe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_in,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [BE_W-1:0]   be_in,
    input  logic              par_in,
    input  xfer_kind_e        kind_in,
    input  xfer_dir_e         dir_in,
    input  logic              en_in,
    output chk_t              chk
);
    localparam int COVER_W = DATA_W + BE_W;

    logic [COVER_W-1:0] covered;
    phase_t             s1;

    assign covered = {ad_in, be_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= '0;
            chk <= '0;
        end else begin
            s1.valid    <= phase_in;
            s1.calc_par <= ^covered;
            s1.kind     <= kind_in;
            s1.dir      <= dir_in;
            s1.en       <= en_in;
            chk.valid    <= s1.valid;
            chk.mismatch <= s1.valid && (par_in != s1.calc_par);
            chk.kind     <= s1.kind;
            chk.dir      <= s1.dir;
            chk.en       <= s1.en;
        end
    end

    // R2: a compared result exists only two clocks after a data phase
    p_chk_two_after_phase_r2: assert property (@(posedge clk) disable iff (rst)
        chk.valid |-> $past(phase_in, 2));

endmodule

// File: rtl/bpe_pri_strobe.sv
module bpe_pri_strobe
    import bpe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  chk_t pri_chk,
    input  logic sec_cross_req,
    input  logic pri_perr_en,
    output logic pri_perr_n,
    output logic cross_pending
);
    logic own_hit;
    logic cross_q;

    assign own_hit = pri_chk.valid && pri_chk.mismatch && pri_chk.en
                     && pri_owns_strobe(pri_chk.kind, pri_chk.dir);

    always_ff @(posedge clk) begin
        if (rst) cross_q <= 1'b0;
        else     cross_q <= sec_cross_req && pri_perr_en;
    end

    assign pri_perr_n    = !(own_hit || cross_q);
    assign cross_pending = cross_q;

    // R4: a disabled primary phase never produces the strobe on its own
    p_no_strobe_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        (pri_chk.valid && !pri_chk.en && !cross_q) |-> pri_perr_n);

    // R4: reserved kind never qualifies
    p_no_strobe_rsvd_r4: assert property (@(posedge clk) disable iff (rst)
        (pri_chk.valid && pri_chk.kind == XK_RSVD && !cross_q) |-> pri_perr_n);

endmodule

// File: rtl/bpe_sec_status.sv
module bpe_sec_status
    import bpe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  chk_t sec_chk,
    input  logic sec_perr_n,
    input  logic stat_clr,
    output logic dpd,
    output logic cross_req
);
    logic strobe_seen;
    logic set_now;

    assign strobe_seen = sec_chk.valid && !sec_perr_n;
    assign set_now     = sec_chk.valid && sec_chk.en && masters_secondary(sec_chk.dir)
                         && (sec_chk.mismatch || !sec_perr_n);
    assign cross_req   = strobe_seen && (sec_chk.dir == DIR_DOWN)
                         && (sec_chk.kind == XK_DELAYED_WR);

    always_ff @(posedge clk) begin
        if (rst)           dpd <= 1'b0;
        else if (set_now)  dpd <= 1'b1;
        else if (stat_clr) dpd <= 1'b0;
    end

    // R7 / R8: only a mastered, enabled secondary phase can raise the bit
    p_set_needs_master_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(dpd) |-> $past(sec_chk.valid && sec_chk.en && sec_chk.dir == DIR_DOWN));

    // R9: the bit falls only after a clear pulse
    p_clear_only_by_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(dpd) |-> $past(stat_clr));

endmodule

// File: rtl/bridge_perr_unit.sv
module bridge_perr_unit
    import bpe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pri_phase,
    input  logic [DATA_W-1:0] pri_ad,
    input  logic [BE_W-1:0]   pri_be,
    input  logic              pri_par,
    input  logic [1:0]        pri_kind,
    input  logic              pri_dir,
    input  logic              pri_perr_en,
    input  logic              sec_phase,
    input  logic [DATA_W-1:0] sec_ad,
    input  logic [BE_W-1:0]   sec_be,
    input  logic              sec_par,
    input  logic [1:0]        sec_kind,
    input  logic              sec_dir,
    input  logic              sec_perr_en,
    input  logic              sec_perr_n,
    input  logic              stat_clr,
    output logic              pri_perr_n,
    output logic              sec_dpd
);
    logic              bus_phase [NUM_BUS];
    logic [DATA_W-1:0] bus_ad    [NUM_BUS];
    logic [BE_W-1:0]   bus_be    [NUM_BUS];
    logic              bus_par   [NUM_BUS];
    xfer_kind_e        bus_kind  [NUM_BUS];
    xfer_dir_e         bus_dir   [NUM_BUS];
    logic              bus_en    [NUM_BUS];
    chk_t              bus_chk   [NUM_BUS];

    logic cross_req;
    logic cross_pending;

    assign bus_phase[BUS_PRI] = pri_phase;
    assign bus_ad[BUS_PRI]    = pri_ad;
    assign bus_be[BUS_PRI]    = pri_be;
    assign bus_par[BUS_PRI]   = pri_par;
    assign bus_kind[BUS_PRI]  = xfer_kind_e'(pri_kind);
    assign bus_dir[BUS_PRI]   = xfer_dir_e'(pri_dir);
    assign bus_en[BUS_PRI]    = pri_perr_en;

    assign bus_phase[BUS_SEC] = sec_phase;
    assign bus_ad[BUS_SEC]    = sec_ad;
    assign bus_be[BUS_SEC]    = sec_be;
    assign bus_par[BUS_SEC]   = sec_par;
    assign bus_kind[BUS_SEC]  = xfer_kind_e'(sec_kind);
    assign bus_dir[BUS_SEC]   = xfer_dir_e'(sec_dir);
    assign bus_en[BUS_SEC]    = sec_perr_en;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        bpe_parity_pipe #(.DATA_W(DATA_W), .BE_W(BE_W)) u_pipe (
            .clk      (clk),
            .rst      (rst),
            .phase_in (bus_phase[b]),
            .ad_in    (bus_ad[b]),
            .be_in    (bus_be[b]),
            .par_in   (bus_par[b]),
            .kind_in  (bus_kind[b]),
            .dir_in   (bus_dir[b]),
            .en_in    (bus_en[b]),
            .chk      (bus_chk[b])
        );
    end

    bpe_sec_status u_status (
        .clk        (clk),
        .rst        (rst),
        .sec_chk    (bus_chk[BUS_SEC]),
        .sec_perr_n (sec_perr_n),
        .stat_clr   (stat_clr),
        .dpd        (sec_dpd),
        .cross_req  (cross_req)
    );

    bpe_pri_strobe u_strobe (
        .clk           (clk),
        .rst           (rst),
        .pri_chk       (bus_chk[BUS_PRI]),
        .sec_cross_req (cross_req),
        .pri_perr_en   (pri_perr_en),
        .pri_perr_n    (pri_perr_n),
        .cross_pending (cross_pending)
    );

    // R1: reset leaves the strobe idle and the status clear
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pri_perr_n && !sec_dpd));

    // R3: the strobe needs a primary mismatch or a carried secondary error
    p_strobe_has_cause_r3: assert property (@(posedge clk) disable iff (rst)
        !pri_perr_n |-> (cross_pending
                         || (bus_chk[BUS_PRI].valid && bus_chk[BUS_PRI].mismatch)));

    // R5 / R6: a carried error comes only from a downstream delayed write
    p_cross_source_r5: assert property (@(posedge clk) disable iff (rst)
        cross_pending |-> $past(bus_chk[BUS_SEC].valid && !sec_perr_n
                                && bus_chk[BUS_SEC].kind == XK_DELAYED_WR
                                && bus_chk[BUS_SEC].dir == DIR_DOWN));

endmodule

// File: tb/tb_bridge_perr_unit.sv
module tb_bridge_perr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pri_phase = 0, pri_par = 0, pri_dir = 0, pri_perr_en = 0;
    logic [DW-1:0] pri_ad = '0;
    logic [BW-1:0] pri_be = '0;
    logic [1:0]    pri_kind = 2'b00;
    logic          sec_phase = 0, sec_par = 0, sec_dir = 0, sec_perr_en = 0;
    logic [DW-1:0] sec_ad = '0;
    logic [BW-1:0] sec_be = '0;
    logic [1:0]    sec_kind = 2'b00;
    logic          sec_perr_n = 1'b1;
    logic          stat_clr = 1'b0;
    logic          pri_perr_n;
    logic          sec_dpd;

    bridge_perr_unit #(.DATA_W(DW), .BE_W(BW)) dut (
        .clk(clk), .rst(rst),
        .pri_phase(pri_phase), .pri_ad(pri_ad), .pri_be(pri_be), .pri_par(pri_par),
        .pri_kind(pri_kind), .pri_dir(pri_dir), .pri_perr_en(pri_perr_en),
        .sec_phase(sec_phase), .sec_ad(sec_ad), .sec_be(sec_be), .sec_par(sec_par),
        .sec_kind(sec_kind), .sec_dir(sec_dir), .sec_perr_en(sec_perr_en),
        .sec_perr_n(sec_perr_n), .stat_clr(stat_clr),
        .pri_perr_n(pri_perr_n), .sec_dpd(sec_dpd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int due;
        bit pri_low;
        bit dpd_set;
        bit dpd_clr;
    } exp_t;

    exp_t  sb_q[$];
    int    cyc = 0;
    int    n_checks = 0;
    int    n_fails = 0;
    bit    mon_on = 0;
    bit    exp_dpd = 0;
    string cur_req = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     req, what, cyc, act, expv);
        end
    endtask

    // monitor: pops scoreboard items due this cycle and compares the outputs
    bit m_low, m_set, m_clr;
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            m_low = 0; m_set = 0; m_clr = 0;
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                m_low |= e.pri_low;
                m_set |= e.dpd_set;
                m_clr |= e.dpd_clr;
            end
            if (m_set)      exp_dpd = 1'b1;
            else if (m_clr) exp_dpd = 1'b0;
            check(pri_perr_n == !m_low, cur_req, "pri_perr_n", pri_perr_n, !m_low);
            check(sec_dpd == exp_dpd, cur_req, "sec_dpd", sec_dpd, exp_dpd);
        end
    end

    // driver: one data phase on a chosen bus, expectations pushed to the queue
    task automatic bus_op(input bit on_sec, input logic [1:0] kind, input bit dir,
                          input logic [DW-1:0] ad, input logic [BW-1:0] be,
                          input bit bad, input bit en, input bit sperr,
                          input bit pen, input bit clr2, input string req);
        int   c;
        exp_t e;
        bit   good_par;
        @(negedge clk);
        c = cyc;
        cur_req = req;
        good_par = ^{ad, be};
        if (on_sec) begin
            sec_phase = 1; sec_ad = ad; sec_be = be; sec_kind = kind; sec_dir = dir;
            sec_perr_en = en; pri_perr_en = pen;
            e.due = c + 3;
            e.dpd_set = (dir == 0) && en && (bad || sperr);
            e.pri_low = (dir == 0) && (kind == 2'b10) && sperr && pen;
            e.dpd_clr = clr2;
            sb_q.push_back(e);
        end else begin
            pri_phase = 1; pri_ad = ad; pri_be = be; pri_kind = kind; pri_dir = dir;
            pri_perr_en = en;
            e.due = c + 2;
            e.pri_low = bad && en && (((dir == 0) && (kind == 2'b01 || kind == 2'b10))
                                      || ((dir == 1) && (kind == 2'b00)));
            e.dpd_set = 0;
            e.dpd_clr = 0;
            sb_q.push_back(e);
        end
        @(negedge clk);
        if (on_sec) begin sec_phase = 0; sec_par = good_par ^ bad; end
        else        begin pri_phase = 0; pri_par = good_par ^ bad; end
        @(negedge clk);
        sec_par = 0; pri_par = 0;
        if (on_sec) sec_perr_n = !sperr;
        stat_clr = clr2;
        @(negedge clk);
        sec_perr_n = 1; stat_clr = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_status(input string req);
        exp_t e;
        @(negedge clk);
        cur_req = req;
        stat_clr = 1;
        e.due = cyc + 1; e.pri_low = 0; e.dpd_set = 0; e.dpd_clr = 1;
        sb_q.push_back(e);
        @(negedge clk);
        stat_clr = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state at the ports
        check(pri_perr_n == 1'b1, "R1", "pri_perr_n after reset", pri_perr_n, 1);
        check(sec_dpd == 1'b0, "R1", "sec_dpd after reset", sec_dpd, 0);
        mon_on = 1;

        // R3: downstream posted write, bad parity -> strobe in T+2
        bus_op(0, 2'b01, 0, 32'hDEAD_BEEF, 4'hF, 1, 1, 0, 1, 0, "R3");
        // R2: same transfer, correct parity -> nothing
        bus_op(0, 2'b01, 0, 32'hDEAD_BEEF, 4'hF, 0, 1, 0, 1, 0, "R2");
        bus_op(0, 2'b10, 0, 32'h0000_0000, 4'h0, 0, 1, 0, 1, 0, "R2");
        // R3: downstream delayed write and upstream read with errors
        bus_op(0, 2'b10, 0, 32'h0000_0001, 4'h3, 1, 1, 0, 1, 0, "R3");
        bus_op(0, 2'b00, 1, 32'hFFFF_FFFF, 4'hF, 1, 1, 0, 1, 0, "R3");
        // R4: non-qualifying cases and disabled response
        bus_op(0, 2'b00, 0, 32'hA5A5_5A5A, 4'h1, 1, 1, 0, 1, 0, "R4");
        bus_op(0, 2'b01, 1, 32'h1234_5678, 4'h8, 1, 1, 0, 1, 0, "R4");
        bus_op(0, 2'b11, 0, 32'h0F0F_0F0F, 4'h6, 1, 1, 0, 1, 0, "R4");
        bus_op(0, 2'b01, 0, 32'hCAFE_F00D, 4'hF, 1, 0, 0, 0, 0, "R4");
        // R5: carried error with the secondary status disabled (R8 too)
        bus_op(1, 2'b10, 0, 32'h1111_2222, 4'hF, 0, 0, 1, 1, 0, "R5");
        // R5: primary enable low in T+2 -> nothing carried
        bus_op(1, 2'b10, 0, 32'h1111_2222, 4'hF, 0, 0, 1, 0, 0, "R5");
        // R6: posted write and read with strobe -> no primary strobe; R7 sets the bit
        bus_op(1, 2'b01, 0, 32'h3333_4444, 4'hC, 0, 1, 1, 1, 0, "R6");
        bus_op(1, 2'b00, 0, 32'h5555_6666, 4'h2, 0, 0, 1, 1, 0, "R6");
        // R9: sticky while no clear, then cleared
        repeat (4) @(negedge clk);
        clear_status("R9");
        // R7: mismatch on a downstream read sets the bit without strobe
        bus_op(1, 2'b00, 0, 32'h7777_8888, 4'hF, 1, 1, 0, 1, 0, "R7");
        clear_status("R9");
        // R8: upstream secondary transfer never sets the bit
        bus_op(1, 2'b00, 1, 32'h9999_AAAA, 4'hF, 1, 1, 1, 1, 0, "R8");
        bus_op(1, 2'b10, 1, 32'hBBBB_CCCC, 4'h5, 1, 1, 1, 1, 0, "R8");
        // R6: stray secondary strobe outside any window is ignored
        @(negedge clk);
        cur_req = "R6";
        sec_perr_n = 0; pri_perr_en = 1;
        @(negedge clk);
        sec_perr_n = 1;
        repeat (3) @(negedge clk);
        // R9: set and clear in the same cycle -> set wins; also R5 and R7 together
        bus_op(1, 2'b10, 0, 32'hDDDD_EEEE, 4'hF, 0, 1, 1, 1, 1, "R9");
        repeat (3) @(negedge clk);
        // R1: reset while the bit is set clears it
        mon_on = 0;
        rst = 1;
        repeat (2) @(negedge clk);
        check(sec_dpd == 1'b0, "R1", "sec_dpd during reset", sec_dpd, 0);
        check(pri_perr_n == 1'b1, "R1", "pri_perr_n during reset", pri_perr_n, 1);
        rst = 0;
        sb_q.delete();
        exp_dpd = 0;
        @(negedge clk);
        mon_on = 1;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        mon_on = 0;
        finish_run();
    end
endmodule